// File: doc/BRIEF.md
# Oversampled NRZ Frame Receiver

This block turns a demodulated one-bit line into bytes. The line is sampled four times per bit period, and each sample arrives with a strobe. The receiver waits on an idle, high line. It qualifies a start-of-frame from the length of the low run that follows. It then realigns on the falling edge of every character's start bit. Each character is ten bits long, and the receiver checks the start and stop bits before writing the data byte through a simple write port. A character that is all zeros closes the frame. The block then raises a one-cycle done pulse and publishes the byte count.

There are four states. RX_HUNT waits for the line to go low. RX_SOF_LOW measures the low run. RX_GAP waits for the next start bit and bounds the idle time. RX_CHAR shifts in one character.

The transitions are as follows:
- hunt→sof_low: a low sample arrives.
- sof_low→gap: the run is accepted.
- sof_low→hunt: the run is too short or too long.
- gap→char: a low sample arrives.
- gap→hunt: the idle time runs out.
- char→gap: a data byte is stored and there is room for more.
- char→hunt: the character is an end mark, a framing error, or the byte that fills the frame.

A `busy` flag is high while the block sits in RX_GAP or RX_CHAR, so a neighbouring receiver can be held off.

Top module: `nrz_frame_rx`

## Requirements
- R1: After reset `busy`, `wr_en` and `frame_done` are 0, `frame_len` is 0, and the block is in RX_HUNT.
- R2: Sample positions count the first low sample after idle as position 0, and the line is read at position 2 of every four-sample bit. A high reading after at least 10 and at most 12 low readings accepts the start-of-frame, and `busy` is 1 from the cycle after that strobe.
- R3: A high reading after 9 or fewer low readings rejects the start-of-frame. The block returns to RX_HUNT, `busy` stays 0, and nothing is written.
- R4: A 13th consecutive low reading abandons the start-of-frame. The block returns to RX_HUNT, and `busy` stays 0.
- R5: In RX_CHAR each bit is read at position 2, counting the start-bit falling sample as position 0, and the first bit received is the start bit. When the first bit is 0 and the tenth bit is 1, `wr_en` pulses for one cycle in the cycle after the tenth reading. `wr_data` then holds bits 2..9 with the second bit received in `wr_data[0]`, and `wr_addr` holds the byte index counted from 0.
- R6: In RX_GAP up to 25 high samples are tolerated. The 26th high sample returns the block to RX_HUNT and drops `busy`.
- R7: A ten-bit character of all zeros ends the frame. If at least one byte was stored, `frame_done` pulses for exactly one cycle with `busy` 0, and `frame_len` equals the number of bytes stored.
- R8: An all-zero character with no bytes stored returns the block to RX_HUNT without a `frame_done` pulse.
- R9: Any other character (start bit 1, or stop bit 0 and not all zero) is a framing error. It returns the block to RX_HUNT with no write and no `frame_done`.
- R10: When the stored byte count reaches `max_len`, which must be at least 1, the byte is still written, but the frame is abandoned. `busy` drops with that write, and no `frame_done` follows.
- R11: `frame_len` changes only together with a `frame_done` pulse.
- R12: Cycles with `smp_valid` low change nothing. State, `busy`, writes and `frame_done` ignore `smp_bit` in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe marking a new line sample |
| smp_bit | input | 1 | Demodulated line level |
| max_len | input | LEN_W | Largest number of bytes a frame may hold |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | LEN_W | Byte index within the frame |
| wr_data | output | DATA_W | Received data byte |
| frame_done | output | 1 | One-cycle pulse on a completed frame |
| frame_len | output | LEN_W | Byte count of the last completed frame |
| busy | output | 1 | Frame in progress after start-of-frame acceptance |

## Verification
The bench builds the receiver with its default parameters: four samples per bit, reading at position 2, a start-of-frame window of 10 to 12 low bits, an idle limit of 25 samples, and 8-bit bytes and lengths. With those values the exact window edges are driven: 9, 10, 12 and 13 low bits, and 25 versus more idle samples. Driving `max_len` at 3 brings the frame-full abandon within reach in a few characters. Stretching the strobe with idle cycles shows that only strobed samples advance the timing.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_SOF_LOW,
        RX_GAP,
        RX_CHAR
    } rx_state_e;

endpackage

// File: rtl/nrz_rx_ctr.sv
// Up counter with synchronous clear (priority) and optional wrap modulus.
module nrz_rx_ctr #(
    parameter int W   = 4,
    parameter int MOD = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] LAST = (MOD > 0) ? W'(MOD - 1) : '0;

    generate
        if (MOD > 0) begin : g_wrap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (clr) q <= '0;
                else if (inc) q <= (q == LAST) ? '0 : q + 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (clr) q <= '0;
                else if (inc) q <= q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/nrz_rx_shifter.sv
// Right-shifting character register; classification looks at the word
// that results from the shift in progress.
module nrz_rx_shifter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift,
    input  logic          din,
    output logic [CW-3:0] data_nxt,
    output logic          is_data,
    output logic          is_end
);
    logic [CW-1:0] word_q;
    logic [CW-1:0] word_nxt;

    assign word_nxt = {din, word_q[CW-1:1]};
    assign data_nxt = word_nxt[CW-2:1];
    assign is_data  = word_nxt[CW-1] & ~word_nxt[0];
    assign is_end   = (word_nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (clr)   word_q <= '0;
        else if (shift) word_q <= word_nxt;
    end
endmodule

// File: rtl/nrz_frame_rx.sv
module nrz_frame_rx
    import nrz_rx_pkg::*;
#(
    parameter int SPB         = 4,
    parameter int SMP_PHASE   = 2,
    parameter int SOF_MIN_LOW = 10,
    parameter int SOF_MAX_LOW = 12,
    parameter int GAP_MAX     = 25,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_bit,
    input  logic [LEN_W-1:0]  max_len,
    output logic              wr_en,
    output logic [LEN_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_done,
    output logic [LEN_W-1:0]  frame_len,
    output logic              busy
);
    localparam int CHAR_W  = DATA_W + 2;
    localparam int RUN_M1  = (GAP_MAX > SOF_MAX_LOW) ? GAP_MAX : SOF_MAX_LOW;
    localparam int RUN_MAX = (RUN_M1 > CHAR_W) ? RUN_M1 : CHAR_W;
    localparam int RUN_W   = $clog2(RUN_MAX + 2);
    localparam int PH_W    = (SPB > 2) ? $clog2(SPB) : 1;

    localparam logic [RUN_W-1:0] SOF_MIN_V  = RUN_W'(SOF_MIN_LOW);
    localparam logic [RUN_W-1:0] SOF_MAX_V  = RUN_W'(SOF_MAX_LOW);
    localparam logic [RUN_W-1:0] GAP_MAX_V  = RUN_W'(GAP_MAX);
    localparam logic [RUN_W-1:0] LAST_BIT_V = RUN_W'(CHAR_W - 1);
    localparam logic [PH_W-1:0]  PH_PRE     = PH_W'(SMP_PHASE - 1);

    rx_state_e st_q, st_d;

    logic [PH_W-1:0]   ph_q;
    logic [RUN_W-1:0]  run_q;
    logic [LEN_W-1:0]  bc_q;
    logic [LEN_W:0]    bc_next;
    logic [DATA_W-1:0] sh_data;
    logic              sh_is_data, sh_is_end;

    logic ph_clr, ph_inc, run_clr, run_inc, sh_clr, sh_shift, bc_clr, bc_inc;
    logic ev_byte, ev_end, at_smp;

    assign at_smp  = smp_valid && (ph_q == PH_PRE);
    assign bc_next = {1'b0, bc_q} + 1'b1;

    // Sample position within the current bit
    nrz_rx_ctr #(.W(PH_W), .MOD(SPB)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .inc(ph_inc), .q(ph_q)
    );

    // Shared run counter: low bits in SOF, idle samples in gap, bits in char
    nrz_rx_ctr #(.W(RUN_W), .MOD(0)) u_run (
        .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc), .q(run_q)
    );

    // Stored byte count
    nrz_rx_ctr #(.W(LEN_W), .MOD(0)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(bc_inc), .q(bc_q)
    );

    nrz_rx_shifter #(.CW(CHAR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift(sh_shift), .din(smp_bit),
        .data_nxt(sh_data), .is_data(sh_is_data), .is_end(sh_is_end)
    );

    always_comb begin
        st_d     = st_q;
        ph_clr   = 1'b0;
        ph_inc   = 1'b0;
        run_clr  = 1'b0;
        run_inc  = 1'b0;
        sh_clr   = 1'b0;
        sh_shift = 1'b0;
        bc_clr   = 1'b0;
        bc_inc   = 1'b0;
        ev_byte  = 1'b0;
        ev_end   = 1'b0;
        unique case (st_q)
            RX_HUNT: begin
                if (smp_valid && !smp_bit) begin
                    st_d    = RX_SOF_LOW;
                    ph_clr  = 1'b1;
                    run_clr = 1'b1;
                end
            end
            RX_SOF_LOW: begin
                ph_inc = smp_valid;
                if (at_smp) begin
                    if (smp_bit) begin
                        if (run_q >= SOF_MIN_V) begin
                            st_d    = RX_GAP;
                            run_clr = 1'b1;
                            bc_clr  = 1'b1;
                        end else begin
                            st_d = RX_HUNT;
                        end
                    end else if (run_q >= SOF_MAX_V) begin
                        st_d = RX_HUNT;
                    end else begin
                        run_inc = 1'b1;
                    end
                end
            end
            RX_GAP: begin
                if (smp_valid) begin
                    if (smp_bit) begin
                        if (run_q >= GAP_MAX_V) st_d = RX_HUNT;
                        else                    run_inc = 1'b1;
                    end else begin
                        st_d    = RX_CHAR;
                        ph_clr  = 1'b1;
                        run_clr = 1'b1;
                        sh_clr  = 1'b1;
                    end
                end
            end
            RX_CHAR: begin
                ph_inc = smp_valid;
                if (at_smp) begin
                    sh_shift = 1'b1;
                    run_inc  = 1'b1;
                    if (run_q == LAST_BIT_V) begin
                        if (sh_is_data) begin
                            ev_byte = 1'b1;
                            bc_inc  = 1'b1;
                            if (bc_next >= {1'b0, max_len}) begin
                                st_d = RX_HUNT;
                            end else begin
                                st_d    = RX_GAP;
                                run_clr = 1'b1;
                            end
                        end else if (sh_is_end) begin
                            st_d   = RX_HUNT;
                            ev_end = (bc_q != '0);
                        end else begin
                            st_d = RX_HUNT;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_HUNT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            busy       <= 1'b0;
        end else begin
            wr_en      <= ev_byte;
            frame_done <= ev_end;
            busy       <= (st_d == RX_GAP) || (st_d == RX_CHAR);
            if (ev_byte) begin
                wr_addr <= bc_q;
                wr_data <= sh_data;
            end
            if (ev_end) frame_len <= bc_q;
        end
    end
endmodule

// File: rtl/nrz_frame_rx_chk.sv
module nrz_frame_rx_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [LEN_W-1:0] max_len,
    input logic             wr_en,
    input logic [LEN_W-1:0] wr_addr,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic             busy
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7
    done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!busy && frame_len != '0));

    // R11
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(frame_len));

    // R10
    full_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |-> ((LEN_W+1)'(wr_addr) + (LEN_W+1)'(1) >= (LEN_W+1)'(max_len)));

    // R10
    room_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |-> ((LEN_W+1)'(wr_addr) + (LEN_W+1)'(1) < (LEN_W+1)'(max_len)));

    // R12
    no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!wr_en && !frame_done));

    // R12
    no_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(busy));
endmodule

bind nrz_frame_rx nrz_frame_rx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .max_len(max_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .frame_done(frame_done),
    .frame_len(frame_len), .busy(busy)
);

// File: tb/nrz_frame_rx_tb_top.sv
module nrz_frame_rx_tb_top;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic       smp_bit = 1'b1;
    logic [7:0] max_len = 8'd16;
    logic       wr_en, frame_done, busy;
    logic [7:0] wr_addr, wr_data, frame_len;

    int n_tests = 0;
    int n_fail  = 0;
    int stretch = 0;
    bit ended   = 1'b0;

    // monitor counters
    int cnt_wr, cnt_done, last_len;
    logic [15:0] wr_log[$];

    always #(CLK_NS/2) clk = ~clk;

    nrz_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
        .max_len(max_len), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_done(frame_done), .frame_len(frame_len), .busy(busy)
    );

    // ---------------- behavioural reference model ----------------
    int         m_mode;   // 0 hunt, 1 sof, 2 gap, 3 char
    int         m_age, m_low, m_idle, m_nbit, m_cnt, m_len;
    logic [9:0] m_chr;
    bit         m_wr, m_done;
    int         m_addr;
    logic [7:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_low = 0; m_idle = 0; m_nbit = 0;
            m_cnt = 0; m_len = 0; m_chr = '0; m_wr = 0; m_done = 0;
            m_addr = 0; m_data = '0;
        end else begin
            m_wr = 0;
            m_done = 0;
            if (smp_valid) begin
                if (m_mode == 0) begin
                    if (!smp_bit) begin m_mode = 1; m_age = 0; m_low = 0; end
                end else if (m_mode == 1) begin
                    m_age++;
                    if (m_age % 4 == 2) begin
                        if (smp_bit) begin
                            if (m_low >= 10) begin m_mode = 2; m_idle = 0; m_cnt = 0; end
                            else m_mode = 0;
                        end else begin
                            m_low++;
                            if (m_low > 12) m_mode = 0;
                        end
                    end
                end else if (m_mode == 2) begin
                    if (smp_bit) begin
                        m_idle++;
                        if (m_idle > 25) m_mode = 0;
                    end else begin
                        m_mode = 3; m_age = 0; m_nbit = 0; m_chr = '0;
                    end
                end else begin
                    m_age++;
                    if (m_age % 4 == 2) begin
                        m_chr[m_nbit] = smp_bit;
                        m_nbit++;
                        if (m_nbit == 10) begin
                            if (m_chr == 10'd0) begin
                                m_mode = 0;
                                if (m_cnt > 0) begin m_done = 1; m_len = m_cnt; end
                            end else if (!m_chr[0] && m_chr[9]) begin
                                m_wr = 1; m_addr = m_cnt; m_data = m_chr[8:1];
                                m_cnt++;
                                if (m_cnt >= int'(max_len)) m_mode = 0;
                                else begin m_mode = 2; m_idle = 0; end
                            end else begin
                                m_mode = 0;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle compare against the model, and port monitor
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            int mb, aw, ew;
            mb = (m_mode == 2 || m_mode == 3) ? 1 : 0;
            chk(busy == mb[0], "R2 busy vs model", busy, mb);
            aw = wr_en ? (65536 + int'(wr_addr) * 256 + int'(wr_data)) : 0;
            ew = m_wr  ? (65536 + m_addr * 256 + int'(m_data)) : 0;
            chk(aw == ew, "R5 write vs model", aw, ew);
            chk(frame_done == m_done, "R7 done vs model", frame_done, m_done);
            chk(int'(frame_len) == m_len, "R11 len vs model", frame_len, m_len);
            if (wr_en) begin cnt_wr++; wr_log.push_back({wr_addr, wr_data}); end
            if (frame_done) begin cnt_done++; last_len = frame_len; end
        end
    end

    // ---------------- stimulus ----------------
    task automatic smp(input logic b);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_bit   = b;
        for (int i = 0; i < stretch; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_bit   = ~b;
        end
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_bit   = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic bitv(input logic b);
        for (int i = 0; i < 4; i++) smp(b);
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) smp(1'b1);
    endtask

    task automatic sof(input int nlow);
        for (int i = 0; i < nlow; i++) bitv(1'b0);
        bitv(1'b1);
    endtask

    task automatic chr(input logic [7:0] d);
        bitv(1'b0);
        for (int i = 0; i < 8; i++) bitv(d[i]);
        bitv(1'b1);
    endtask

    task automatic eof_mark();
        for (int i = 0; i < 10; i++) bitv(1'b0);
        bitv(1'b1);
        bitv(1'b1);
    endtask

    task automatic start_scn();
        cnt_wr = 0;
        cnt_done = 0;
        last_len = -1;
        wr_log.delete();
    endtask

    task automatic settle();
        highs(30);
        quiet(2);
    endtask

    task automatic report();
        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        logic [7:0] rb[6];
        logic [7:0] held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0,       "R1 busy",       busy, 0);
        chk(wr_en == 1'b0,      "R1 wr_en",      wr_en, 0);
        chk(frame_done == 1'b0, "R1 frame_done", frame_done, 0);
        chk(frame_len == 8'd0,  "R1 frame_len",  frame_len, 0);

        // R2 R5 R7: minimum SOF, two bytes
        start_scn();
        sof(10);
        quiet(1);
        chk(busy == 1'b1, "R2 busy after 10-bit SOF", busy, 1);
        chr(8'hA5);
        chr(8'h3C);
        eof_mark();
        quiet(2);
        chk(cnt_wr == 2, "R5 write count", cnt_wr, 2);
        if (wr_log.size() >= 2) begin
            chk(wr_log[0] == 16'h00A5, "R5 first byte/addr", wr_log[0], 16'h00A5);
            chk(wr_log[1] == 16'h013C, "R5 second byte/addr", wr_log[1], 16'h013C);
        end
        chk(cnt_done == 1, "R7 done count", cnt_done, 1);
        chk(last_len == 2, "R7 frame length", last_len, 2);
        chk(busy == 1'b0, "R7 busy after end", busy, 0);
        settle();

        // R2 R12: maximum SOF with stretched strobes
        start_scn();
        stretch = 2;
        sof(12);
        chr(8'h00);
        chr(8'hFF);
        chr(8'h81);
        eof_mark();
        quiet(3);
        chk(cnt_wr == 3, "R12 writes with strobe gaps", cnt_wr, 3);
        chk(cnt_done == 1 && last_len == 3, "R2 12-bit SOF frame length", last_len, 3);
        stretch = 0;
        settle();

        // R3: SOF one bit short
        start_scn();
        sof(9);
        quiet(1);
        chk(busy == 1'b0, "R3 busy after 9-bit SOF", busy, 0);
        chr(8'h55);
        eof_mark();
        settle();
        chk(cnt_wr == 0, "R3 no writes", cnt_wr, 0);
        chk(cnt_done == 0, "R3 no done", cnt_done, 0);
        chk(frame_len == 8'd3, "R11 length held", frame_len, 3);

        // R4: SOF one bit long
        start_scn();
        sof(13);
        quiet(1);
        chk(busy == 1'b0, "R4 busy after 13-bit SOF", busy, 0);
        chr(8'h12);
        eof_mark();
        settle();
        chk(cnt_wr == 0, "R4 no writes", cnt_wr, 0);
        chk(cnt_done == 0, "R4 no done", cnt_done, 0);

        // R6: gap of exactly 25 idle samples is tolerated
        start_scn();
        sof(10);
        chr(8'h01);
        highs(24);
        chr(8'h02);
        eof_mark();
        quiet(2);
        chk(cnt_wr == 2, "R6 writes across 25-sample gap", cnt_wr, 2);
        chk(cnt_done == 1 && last_len == 2, "R6 frame across 25-sample gap", last_len, 2);
        settle();

        // R6: gap timeout
        start_scn();
        sof(11);
        chr(8'h5A);
        highs(30);
        quiet(1);
        chk(busy == 1'b0, "R6 busy after long gap", busy, 0);
        chr(8'h77);
        settle();
        chk(cnt_wr == 1, "R6 writes before timeout", cnt_wr, 1);
        chk(cnt_done == 0, "R6 no done after timeout", cnt_done, 0);

        // R8: empty frame
        start_scn();
        sof(10);
        for (int i = 0; i < 10; i++) bitv(1'b0);
        bitv(1'b1);
        quiet(1);
        chk(busy == 1'b0, "R8 busy after empty end", busy, 0);
        settle();
        chk(cnt_done == 0, "R8 no done on empty frame", cnt_done, 0);
        chk(frame_len == 8'd2, "R11 length held after empty", frame_len, 2);

        // R9: framing error (stop bit 0)
        start_scn();
        sof(10);
        chr(8'h33);
        bitv(1'b0);
        for (int i = 0; i < 8; i++) bitv(i >= 4);
        bitv(1'b0);
        highs(8);
        quiet(1);
        chk(busy == 1'b0, "R9 busy after framing error", busy, 0);
        settle();
        chk(cnt_wr == 1, "R9 only good byte written", cnt_wr, 1);
        chk(cnt_done == 0, "R9 no done", cnt_done, 0);

        // R10: frame fills max_len
        start_scn();
        max_len = 8'd3;
        sof(10);
        chr(8'h01);
        chr(8'h02);
        chr(8'h03);
        quiet(1);
        chk(busy == 1'b0, "R10 busy after full", busy, 0);
        chr(8'h04);
        eof_mark();
        settle();
        chk(cnt_wr == 3, "R10 writes until full", cnt_wr, 3);
        if (wr_log.size() == 3)
            chk(wr_log[2] == 16'h0203, "R10 last byte/addr", wr_log[2], 16'h0203);
        chk(cnt_done == 0, "R10 no done", cnt_done, 0);
        max_len = 8'd16;

        // R5 R7 R12: pseudo-random bytes, varying strobe spacing
        start_scn();
        sof(11);
        for (int i = 0; i < 6; i++) begin
            rb[i] = 8'($urandom_range(0, 255));
            if (rb[i] == 8'h00) rb[i] = 8'h5E;
            stretch = i % 3;
            chr(rb[i]);
        end
        stretch = 1;
        eof_mark();
        stretch = 0;
        quiet(3);
        chk(cnt_wr == 6, "R5 random frame writes", cnt_wr, 6);
        for (int i = 0; i < 6; i++) begin
            if (wr_log.size() > i) begin
                held = wr_log[i][7:0];
                chk(held == rb[i], "R5 random byte", held, rb[i]);
            end
        end
        chk(cnt_done == 1 && last_len == 6, "R7 random frame length", last_len, 6);
        settle();

        report();
    end
endmodule